// File: doc/BRIEF.md
# Correlated-Double-Sampling Pixel Coadder

This block sums successive detector frames into a frame memory that holds a 32-bit total for every pixel. Pixel samples arrive on a valid/ready stream fed from an input FIFO. For each sample the block reads the running total from a synchronous memory, adds the sample, and writes the result back to the same address on the next cycle. The read, add and write are pipelined, so one pixel can be retired on every clock. Only the low 16 bits of each incoming word are added. The remaining bits of the word carry no pixel data and are dropped.

The memory holds two banks. One bank collects the reset frames and the other collects the expose frames. Each bank covers one frame made of two pages. A job is started with three settings: a coadd count, a correlated-double-sampling enable and a Fowler count. For every coadd, the reset frame is summed Fowler-count times when the enable is set. The expose frame is then summed Fowler-count times. A separate clear command writes zero to every address of both banks. Either command raises a one-cycle flush pulse for the external FIFOs. Each command ends with a one-cycle done pulse.

Top module: `cds_coadder`

## Requirements
- R1: While reset is held and in the first cycle after it: busy, done, fifo_flush, s_ready, mem_rd_en and mem_wr_en are all low.
- R2: Only bits [15:0] of s_data are added. Bits [23:16] have no effect on any written total.
- R3: A sample accepted in cycle t causes a read of its address in cycle t, and a write to that same address in cycle t+1. The written value is the read total plus the sample, wrapping modulo 2^32 with no saturation.
- R4: Address bit [PIX_AW+1] selects the bank (0 = reset, 1 = expose). Bit [PIX_AW] selects the page, and bits [PIX_AW-1:0] select the pixel. Each frame pass visits page 0 and then page 1, with pixels in ascending order in each page.
- R5: With cfg_cds = 1, each coadd runs cfg_fowler passes over bank 0, followed by cfg_fowler passes over bank 1.
- R6: With cfg_cds = 0, every pass uses bank 1 and bank 0 is never written.
- R7: A clear command (init) writes zero to every address of both banks, in ascending address order. It accepts no samples (s_ready stays low).
- R8: When a start or init is accepted in cycle c, fifo_flush is high for exactly cycle c+1 and busy is high from cycle c+1.
- R9: done is high for exactly one cycle, the cycle after the final memory write of the job. busy is low in that cycle.
- R10: start and init pulses that arrive while busy is high are ignored. The settings latched at acceptance stay in force and no flush pulse is raised.
- R11: A start with cfg_coadds = 0 or cfg_fowler = 0 performs no memory access and raises done in cycle c+3.
- R12: s_ready is high only while a frame pass is running. A sample is consumed only in a cycle where s_valid and s_ready are both high, and a cycle with s_valid low stalls the pass without skipping an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a coadd job (sampled when idle) |
| init | input | 1 | Begin zeroing both banks (sampled when idle, wins over start) |
| cfg_coadds | input | CNT_W | Number of coadds |
| cfg_cds | input | 1 | 1 = also sum the reset frame |
| cfg_fowler | input | CNT_W | Passes per frame per coadd |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| fifo_flush | output | 1 | One-cycle pulse to empty the external FIFOs |
| s_valid | input | 1 | Sample available (FIFO not empty) |
| s_ready | output | 1 | Block takes the sample this cycle |
| s_data | input | IN_W | Sample word; only the low SAMP_W bits are used |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | PIX_AW+2 | Read address |
| mem_rd_data | input | ACC_W | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | PIX_AW+2 | Write address |
| mem_wr_data | output | ACC_W | Write data |

## Verification
Each accepted sample must show up as a memory write one cycle later. The flush pulse is due one cycle after an accepted command. Done is due one cycle after the final write, or three cycles after a start whose counts are zero. A monitor samples on the falling edge and compares every write, in order, against a queue of expected address/total pairs that the driver builds from the loop order. The done and flush cycles are checked against the recorded cycles of the last write and of the command pulse. After each job, the bench memory is compared with the expected image.

// File: rtl/coadd_pkg.sv
package coadd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_CLEAR,
    ST_ACCUM,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/coadd_seq.sv
module coadd_seq
  import coadd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             init,
  input  logic [CNT_W-1:0] cfg_coadds,
  input  logic             cfg_cds,
  input  logic [CNT_W-1:0] cfg_fowler,
  input  logic             frame_end,
  output logic             busy,
  output logic             done,
  output logic             flush,
  output logic             run,
  output logic             zero_mode,
  output logic             bank
);
  seq_state_t       state_q;
  logic             clr_job_q, cds_q, bank_q, done_q, flush_q;
  logic [CNT_W-1:0] coadds_q, fowler_q, co_cnt_q, fs_cnt_q;
  logic             counts_zero, fs_last, co_last;

  assign counts_zero = (coadds_q == '0) || (fowler_q == '0);
  assign fs_last     = (fs_cnt_q == fowler_q - 1'b1);
  assign co_last     = (co_cnt_q == coadds_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      clr_job_q <= 1'b0;
      cds_q     <= 1'b0;
      bank_q    <= 1'b0;
      done_q    <= 1'b0;
      flush_q   <= 1'b0;
      coadds_q  <= '0;
      fowler_q  <= '0;
      co_cnt_q  <= '0;
      fs_cnt_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (init) begin
            clr_job_q <= 1'b1;
            flush_q   <= 1'b1;
            state_q   <= ST_PREP;
          end else if (start) begin
            clr_job_q <= 1'b0;
            flush_q   <= 1'b1;
            coadds_q  <= cfg_coadds;
            fowler_q  <= cfg_fowler;
            cds_q     <= cfg_cds;
            state_q   <= ST_PREP;
          end
        end
        ST_PREP: begin
          co_cnt_q <= '0;
          fs_cnt_q <= '0;
          if (clr_job_q) begin
            bank_q  <= 1'b0;
            state_q <= ST_CLEAR;
          end else if (counts_zero) begin
            state_q <= ST_DRAIN;
          end else begin
            bank_q  <= !cds_q;
            state_q <= ST_ACCUM;
          end
        end
        ST_CLEAR: begin
          if (frame_end) begin
            if (!bank_q) bank_q <= 1'b1;
            else         state_q <= ST_DRAIN;
          end
        end
        ST_ACCUM: begin
          if (frame_end) begin
            if (!fs_last) begin
              fs_cnt_q <= fs_cnt_q + 1'b1;
            end else begin
              fs_cnt_q <= '0;
              if (!bank_q) begin
                bank_q <= 1'b1;
              end else if (!co_last) begin
                co_cnt_q <= co_cnt_q + 1'b1;
                bank_q   <= !cds_q;
              end else begin
                state_q <= ST_DRAIN;
              end
            end
          end
        end
        ST_DRAIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign flush     = flush_q;
  assign run       = (state_q == ST_ACCUM) || (state_q == ST_CLEAR);
  assign zero_mode = (state_q == ST_CLEAR);
  assign bank      = bank_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (start || init)) |=> ($stable(coadds_q) && $stable(fowler_q) && !flush));
endmodule

// File: rtl/coadd_scan.sv
module coadd_scan #(
  parameter int PIX_AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            step,
  output logic [PIX_AW:0] pos,
  output logic            frame_end
);
  logic [PIX_AW:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pos_q <= '0;
    else if (step)         pos_q <= pos_q + 1'b1;
  end

  assign pos       = pos_q;
  assign frame_end = step && (&pos_q);

  // R4
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pos == '0));

  // R12
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(pos));
endmodule

// File: rtl/coadd_rmw.sv
module coadd_rmw #(
  parameter int ADDR_W = 18,
  parameter int IN_W   = 24,
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              zero_mode,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [IN_W-1:0]   sample_in,
  input  logic [ACC_W-1:0]  mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [ACC_W-1:0]  mem_wr_data
);
  logic [ACC_W-1:0]  samp_ext, samp_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q, zero_q;

  generate
    if (ACC_W > SAMP_W) begin : g_widen
      assign samp_ext = {{(ACC_W-SAMP_W){1'b0}}, sample_in[SAMP_W-1:0]};
    end else begin : g_trunc
      assign samp_ext = sample_in[ACC_W-1:0];
    end
    if (IN_W > SAMP_W) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^sample_in[IN_W-1:SAMP_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      zero_q <= 1'b0;
      addr_q <= '0;
      samp_q <= '0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        addr_q <= issue_addr;
        zero_q <= zero_mode;
        samp_q <= samp_ext;
      end
    end
  end

  assign mem_rd_en   = issue && !zero_mode;
  assign mem_rd_addr = issue_addr;
  assign mem_wr_en   = pend_q;
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = zero_q ? '0 : (mem_rd_data + samp_q);

  // R3
  rmw_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (mem_wr_en && (mem_wr_addr == $past(issue_addr))));

  // R3
  rmw_no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_wr_en) |-> (mem_rd_addr != mem_wr_addr));
endmodule

// File: rtl/cds_coadder.sv
module cds_coadder #(
  parameter int PIX_AW = 16,
  parameter int CNT_W  = 16,
  parameter int IN_W   = 24,
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              init,
  input  logic [CNT_W-1:0]  cfg_coadds,
  input  logic              cfg_cds,
  input  logic [CNT_W-1:0]  cfg_fowler,
  output logic              busy,
  output logic              done,
  output logic              fifo_flush,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [IN_W-1:0]   s_data,
  output logic              mem_rd_en,
  output logic [PIX_AW+1:0] mem_rd_addr,
  input  logic [ACC_W-1:0]  mem_rd_data,
  output logic              mem_wr_en,
  output logic [PIX_AW+1:0] mem_wr_addr,
  output logic [ACC_W-1:0]  mem_wr_data
);
  localparam int ADDR_W = PIX_AW + 2;

  logic            run, zero_mode, bank, frame_end, issue;
  logic [PIX_AW:0] pos;

  assign s_ready = run && !zero_mode;
  assign issue   = run && (zero_mode || s_valid);

  coadd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .init       (init),
    .cfg_coadds (cfg_coadds),
    .cfg_cds    (cfg_cds),
    .cfg_fowler (cfg_fowler),
    .frame_end  (frame_end),
    .busy       (busy),
    .done       (done),
    .flush      (fifo_flush),
    .run        (run),
    .zero_mode  (zero_mode),
    .bank       (bank)
  );

  coadd_scan #(.PIX_AW(PIX_AW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (fifo_flush),
    .step      (issue),
    .pos       (pos),
    .frame_end (frame_end)
  );

  coadd_rmw #(
    .ADDR_W (ADDR_W),
    .IN_W   (IN_W),
    .SAMP_W (SAMP_W),
    .ACC_W  (ACC_W)
  ) u_rmw (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .zero_mode   (zero_mode),
    .issue_addr  ({bank, pos}),
    .sample_in   (s_data),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data)
  );
endmodule

// File: tb/sim_cds_coadder.sv
module sim_cds_coadder;
  localparam int PIX_AW = 2;
  localparam int CNT_W  = 8;
  localparam int IN_W   = 24;
  localparam int SAMP_W = 16;
  localparam int ACC_W  = 32;
  localparam int AW     = PIX_AW + 2;
  localparam int DEPTH  = 1 << AW;
  localparam int FRAME  = 1 << (PIX_AW + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, init, cfg_cds;
  logic [CNT_W-1:0] cfg_coadds, cfg_fowler;
  logic busy, done, fifo_flush, s_valid, s_ready, mem_rd_en, mem_wr_en;
  logic [IN_W-1:0]  s_data;
  logic [AW-1:0]    mem_rd_addr, mem_wr_addr;
  logic [ACC_W-1:0] mem_rd_data, mem_wr_data;

  cds_coadder #(.PIX_AW(PIX_AW), .CNT_W(CNT_W), .IN_W(IN_W), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init(init),
    .cfg_coadds(cfg_coadds), .cfg_cds(cfg_cds), .cfg_fowler(cfg_fowler),
    .busy(busy), .done(done), .fifo_flush(fifo_flush),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int n_compared = 0;
  int n_failed   = 0;
  int cyc        = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-owned frame memory, one-cycle read latency
  logic [ACC_W-1:0] ram [DEPTH];
  logic             preset_en = 1'b0;
  logic [AW-1:0]    preset_addr = '0;
  logic [ACC_W-1:0] preset_val = '0;
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= ram[mem_rd_addr];
    if (mem_wr_en) ram[mem_wr_addr] <= mem_wr_data;
    else if (preset_en) ram[preset_addr] <= preset_val;
  end

  // sample source
  logic [IN_W-1:0] feed_mem [256];
  int   n_feed = 0;
  int   taken = 0;
  int   gap_mode = 0;
  logic gate = 1'b1;
  logic force_valid = 1'b0;
  always @(negedge clk) gate <= (gap_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  assign s_valid = gate && ((taken < n_feed) || force_valid);
  assign s_data  = (taken < n_feed) ? feed_mem[taken[7:0]] : 24'hDEAD00;
  always @(posedge clk) if (s_valid && s_ready) taken <= taken + 1;

  // scoreboard
  typedef struct packed {
    logic [AW-1:0]    a;
    logic [ACC_W-1:0] d;
  } wr_t;
  wr_t exp_q[$];
  logic [ACC_W-1:0] model [DEPTH];
  int last_wr_cyc = 0;
  int flush_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_compared++;
    if (!ok) begin
      n_failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    wr_t e;
    if (rst_n && mem_wr_en) begin
      last_wr_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected write at address", 64'(mem_wr_addr), 64'(0));
      end else begin
        e = exp_q.pop_front();
        check(mem_wr_addr == e.a, "R4", "write address", 64'(mem_wr_addr), 64'(e.a));
        check(mem_wr_data == e.d, "R2 R3", "write total", 64'(mem_wr_data), 64'(e.d));
      end
    end
    if (fifo_flush) flush_cnt++;
  end

  task automatic plan_job(input int nco, input bit cds, input int nfs);
    logic [IN_W-1:0] s;
    wr_t w;
    int addr;
    for (int c = 0; c < nco; c++)
      for (int ph = 0; ph < 2; ph++) begin
        if (ph == 0 && !cds) continue;
        for (int f = 0; f < nfs; f++)
          for (int p = 0; p < FRAME; p++) begin
            s = {8'(n_feed * 29 + 8'h5A), 16'(16'hFF80 + n_feed * 211)};
            feed_mem[n_feed[7:0]] = s;
            n_feed++;
            addr = ph * FRAME + p;
            model[addr] = model[addr] + {16'h0, s[15:0]};
            w.a = AW'(addr);
            w.d = model[addr];
            exp_q.push_back(w);
          end
      end
  endtask

  task automatic pulse_cmd(input bit is_init, input bit accept, output int sc);
    @(negedge clk);
    if (is_init) init = 1'b1; else start = 1'b1;
    sc = cyc;
    @(negedge clk);
    start = 1'b0;
    init  = 1'b0;
    if (accept) begin
      check(fifo_flush == 1'b1, "R8", "flush one cycle after command", 64'(fifo_flush), 64'(1));
      check(busy == 1'b1, "R8", "busy after command", 64'(busy), 64'(1));
      @(negedge clk);
      check(fifo_flush == 1'b0, "R8", "flush width", 64'(fifo_flush), 64'(0));
    end else begin
      check(fifo_flush == 1'b0, "R10", "flush on ignored command", 64'(fifo_flush), 64'(0));
    end
  endtask

  task automatic wait_done(input bit had_writes, output int done_at);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    done_at = cyc;
    check(done == 1'b1, "R9", "done seen", 64'(done), 64'(1));
    check(busy == 1'b0, "R9", "busy low with done", 64'(busy), 64'(0));
    if (had_writes)
      check(done_at == last_wr_cyc + 1, "R9", "done cycle after last write",
            64'(done_at), 64'(last_wr_cyc + 1));
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse width", 64'(done), 64'(0));
  endtask

  task automatic compare_mem(input string req);
    for (int i = 0; i < DEPTH; i++)
      check(ram[i] == model[i], req, $sformatf("memory word %0d", i), 64'(ram[i]), 64'(model[i]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_compared++;
    n_failed++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_failed);
    $finish;
  end

  initial begin : driver
    int sc, dn, t0, fc;
    logic [ACC_W-1:0] bank0_snap [FRAME];
    rst_n = 1'b0; start = 1'b0; init = 1'b0;
    cfg_coadds = '0; cfg_fowler = '0; cfg_cds = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && fifo_flush == 0, "R1", "control outputs in reset",
          64'({busy, done, fifo_flush}), 64'(0));
    check(s_ready == 0 && mem_rd_en == 0 && mem_wr_en == 0, "R1", "strobes in reset",
          64'({s_ready, mem_rd_en, mem_wr_en}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && s_ready == 0 && mem_wr_en == 0, "R1", "idle after reset",
          64'({busy, s_ready, mem_wr_en}), 64'(0));

    // R7 clear both banks, with a valid stream offered that must be left alone
    force_valid = 1'b1;
    t0 = taken;
    for (int i = 0; i < DEPTH; i++) begin
      wr_t w;
      model[i] = '0;
      w.a = AW'(i);
      w.d = '0;
      exp_q.push_back(w);
    end
    pulse_cmd(1'b1, 1'b1, sc);
    wait_done(1'b1, dn);
    force_valid = 1'b0;
    check(taken == t0, "R7", "samples consumed by clear", 64'(taken), 64'(t0));
    check(exp_q.size() == 0, "R7", "clear writes outstanding", 64'(exp_q.size()), 64'(0));
    compare_mem("R7");

    // R5 R3 wrap: cds on, 2 coadds, 2 Fowler passes, gappy stream (R12)
    @(negedge clk);
    preset_en = 1'b1; preset_addr = AW'(FRAME + 1); preset_val = 32'hFFFF_FFF0;
    @(negedge clk);
    preset_en = 1'b0;
    model[FRAME + 1] = 32'hFFFF_FFF0;
    gap_mode = 1;
    cfg_coadds = 8'd2; cfg_cds = 1'b1; cfg_fowler = 8'd2;
    plan_job(2, 1'b1, 2);
    pulse_cmd(1'b0, 1'b1, sc);
    wait_done(1'b1, dn);
    check(exp_q.size() == 0, "R5", "writes outstanding", 64'(exp_q.size()), 64'(0));
    check(taken == n_feed, "R12", "samples consumed", 64'(taken), 64'(n_feed));
    check(ram[FRAME + 1] < 32'h0010_0000, "R3", "total wrapped modulo 2^32",
          64'(ram[FRAME + 1]), 64'(model[FRAME + 1]));
    compare_mem("R5");

    // R6 cds off; R10 pulses while busy are ignored
    for (int i = 0; i < FRAME; i++) bank0_snap[i] = ram[i];
    gap_mode = 0;
    cfg_coadds = 8'd3; cfg_cds = 1'b0; cfg_fowler = 8'd1;
    plan_job(3, 1'b0, 1);
    pulse_cmd(1'b0, 1'b1, sc);
    fc = flush_cnt;
    cfg_coadds = 8'd1; cfg_cds = 1'b1; cfg_fowler = 8'd3;
    repeat (3) @(negedge clk);
    pulse_cmd(1'b0, 1'b0, sc);
    pulse_cmd(1'b1, 1'b0, sc);
    wait_done(1'b1, dn);
    check(flush_cnt == fc, "R10", "flushes during busy", 64'(flush_cnt), 64'(fc));
    check(exp_q.size() == 0, "R10", "writes outstanding", 64'(exp_q.size()), 64'(0));
    check(taken == n_feed, "R12", "samples consumed", 64'(taken), 64'(n_feed));
    for (int i = 0; i < FRAME; i++)
      check(ram[i] == bank0_snap[i], "R6", $sformatf("reset bank word %0d", i),
            64'(ram[i]), 64'(bank0_snap[i]));
    compare_mem("R6");

    // R11 zero counts
    cfg_coadds = 8'd0; cfg_cds = 1'b1; cfg_fowler = 8'd2;
    pulse_cmd(1'b0, 1'b1, sc);
    wait_done(1'b0, dn);
    check(dn == sc + 3, "R11", "done cycle with zero coadds", 64'(dn), 64'(sc + 3));
    cfg_coadds = 8'd2; cfg_fowler = 8'd0;
    pulse_cmd(1'b0, 1'b1, sc);
    wait_done(1'b0, dn);
    check(dn == sc + 3, "R11", "done cycle with zero Fowler", 64'(dn), 64'(sc + 3));
    check(taken == n_feed, "R11", "samples consumed", 64'(taken), 64'(n_feed));
    compare_mem("R11");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_failed);
    $finish;
  end
endmodule